// File: doc/BRIEF.md
# DMA Bus Hold Limiter

This block sits between a multi-channel DMA engine and the system bus arbiter. It passes the engine's bus request up to the arbiter and the arbiter's grant back down. When its timer is armed, it caps how long the DMA may keep the bus. After a programmed number of 256-cycle units of continuous ownership, it withdraws the request even though work is still pending. It then stays off the bus for a fixed 16-cycle back-off so that other masters can get in, and after that it asks for the bus again by itself.

A small register port holds three things: the per-channel enables, the limit word (an arm bit and a 7-bit unit count), and a set of software-start flags. Every forced release clears all the software-start flags, so software cannot use them to detect that a transfer has finished. The limit word is locked while any channel is enabled. Address generation, data movement and choosing between channels belong to the engine. Here they appear only as a single pending-work input.

Top module: `dma_hold_limiter`

## Requirements
- R1: After reset, the channel enables, the limit word and the software-start flags all read back as zero, and `bus_req_o` is low.
- R2: A write to address 0 loads the six channel-enable bits from `cfg_wdata_i[5:0]`. Bit n enables channel n, and the value reads back on `ch_en_o`.
- R3: A write to address 1 loads the limit word: bit 7 arms the timer and bits 6:0 give the unit count. This write is ignored whenever any channel-enable bit is set.
- R4: The limiter is active when the timer is armed and the unit count U is non-zero. While it is active, `dma_gnt_o` stays high for exactly U×256 consecutive cycles. After that, `bus_req_o` drops even though work is still pending.
- R5: After a forced release, `bus_req_o` stays low for exactly 16 cycles. It then rises again by itself if work is still pending.
- R6: When the timer is not armed, or when it is armed with a unit count of zero, the request follows the pending work. The hold time is then unlimited and there is no back-off.
- R7: A write to address 2 loads the six software-start flags from `cfg_wdata_i[5:0]`. Every forced release clears all of these flags to zero.
- R8: The occupancy count restarts whenever the request drops. A voluntary release part-way through a hold is therefore followed by a fresh full U×256 window.
- R9: Outside back-off, `bus_req_o` is high when `dma_pend_i` is high and at least one channel is enabled. `dma_gnt_o` is high only when `bus_gnt_i` and `bus_req_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 enables, 1 limit word, 2 software start |
| cfg_wdata_i | input | 8 | Register write data |
| ch_en_o | output | 6 | Channel-enable read-back |
| lim_cfg_o | output | 8 | Limit word read-back (bit 7 arm, bits 6:0 units) |
| sw_start_o | output | 6 | Software-start flag read-back |
| dma_pend_i | input | 1 | Engine has transfer work outstanding |
| dma_gnt_o | output | 1 | Grant passed to the engine |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Grant from the arbiter |

## Verification
The bench measures the exact length of each grant run and each back-off gap, so an off-by-one in the terminal count or in the back-off counter shows up as a run of 255 or 257 cycles, or as a gap of 15 or 17 cycles. It drops the work part-way through one hold and then restarts it. A counter that failed to clear would cut the next window short. It disarms the timer and also arms it with a zero unit count, and a design that still limited in either case would end a 600-cycle or 300-cycle run early. It also writes the limit word while channels are enabled, and checks that the software-start flags are cleared at the forced release, because a missing lock or a missing clear leaves a stale value on the read-back.

// File: rtl/dhl_pkg.sv
package dhl_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef logic [ADDR_W-1:0] cfg_addr_t;
  localparam cfg_addr_t A_CHEN  = 2'd0;
  localparam cfg_addr_t A_LIMIT = 2'd1;
  localparam cfg_addr_t A_SWST  = 2'd2;
  typedef enum logic {ST_RUN, ST_BACKOFF} hold_st_t;
endpackage

// File: rtl/dhl_rst_sync.sv
module dhl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dhl_regs.sv
module dhl_regs
  import dhl_pkg::*;
#(
  parameter int unsigned NCH   = 6,
  parameter int unsigned LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cfg_addr_t        addr,
  input  logic [LIM_W:0]   wdata,
  input  logic             force_clr,
  output logic [NCH-1:0]   ch_en,
  output logic             lim_arm,
  output logic [LIM_W-1:0] lim_val,
  output logic [NCH-1:0]   sw_start
);
  logic             chen_we, lim_we, swst_we;
  logic [LIM_W:0]   lim_q, lim_d;
  logic [NCH-1:0]   chen_q, chen_d;

  always_comb begin
    chen_we = wr_en && (addr == A_CHEN);
    lim_we  = wr_en && (addr == A_LIMIT) && (chen_q == '0);
    swst_we = wr_en && (addr == A_SWST);
    chen_d  = wdata[NCH-1:0];
    lim_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chen_q <= '0;
    else if (chen_we) chen_q <= chen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_we) lim_q <= lim_d;
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_swst
    logic bit_q, bit_d, bit_en;
    always_comb begin
      bit_en = force_clr || swst_we;
      bit_d  = force_clr ? 1'b0 : wdata[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end
    assign sw_start[gi] = bit_q;
  end

  assign ch_en   = chen_q;
  assign lim_arm = lim_q[LIM_W];
  assign lim_val = lim_q[LIM_W-1:0];

  assert_limit_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LIMIT && |ch_en) |=> $stable({lim_arm, lim_val}));

  assert_swstart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> (sw_start == '0));
endmodule

// File: rtl/dhl_occ_timer.sv
module dhl_occ_timer
  import dhl_pkg::*;
#(
  parameter int unsigned LIM_W     = 7,
  parameter int unsigned UNIT_LOG2 = 8,
  parameter int unsigned BACKOFF   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             work,
  input  logic [LIM_W-1:0] lim_val,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             dma_gnt,
  output logic             force_rel
);
  localparam int unsigned CNT_W = LIM_W + UNIT_LOG2;
  localparam int unsigned BO_W  = (BACKOFF > 1) ? $clog2(BACKOFF) : 1;
  localparam logic [BO_W-1:0] BO_LAST = BO_W'(BACKOFF - 1);

  hold_st_t         st_q, st_d;
  logic [CNT_W-1:0] occ_q, occ_d, hold_n;
  logic [BO_W-1:0]  bo_q, bo_d;
  logic             occ_en, bo_en;

  always_comb begin
    hold_n    = {lim_val, {UNIT_LOG2{1'b0}}};
    bus_req   = work && (st_q == ST_RUN);
    dma_gnt   = bus_gnt && bus_req;
    force_rel = active && dma_gnt && (occ_q == hold_n - CNT_W'(1));
  end

  always_comb begin
    occ_en = !bus_req || dma_gnt;
    occ_d  = (!bus_req || force_rel) ? '0 : occ_q + CNT_W'(1);
  end

  always_comb begin
    st_d  = st_q;
    bo_en = (st_q == ST_BACKOFF) || (bo_q != '0);
    bo_d  = (st_q == ST_BACKOFF) ? bo_q + BO_W'(1) : '0;
    if (!active) begin
      st_d = ST_RUN;
    end else if (st_q == ST_RUN) begin
      if (force_rel) st_d = ST_BACKOFF;
    end else if (bo_q == BO_LAST) begin
      st_d = ST_RUN;
      bo_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bo_q <= '0;
    else if (bo_en) bo_q <= bo_d;
  end

  assert_hold_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dma_gnt) |-> (occ_q < hold_n));

  assert_backoff_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BACKOFF) |-> !bus_req);

  assert_backoff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st_q == ST_BACKOFF && bo_q != BO_LAST) |=> (st_q == ST_BACKOFF));

  assert_force_enters_backoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_rel |=> !bus_req);

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (bus_req == work));
endmodule

// File: rtl/dma_hold_limiter.sv
module dma_hold_limiter
  import dhl_pkg::*;
#(
  parameter int unsigned NCH       = 6,
  parameter int unsigned LIM_W     = 7,
  parameter int unsigned UNIT_LOG2 = 8,
  parameter int unsigned BACKOFF   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [LIM_W:0]   cfg_wdata_i,
  output logic [NCH-1:0]   ch_en_o,
  output logic [LIM_W:0]   lim_cfg_o,
  output logic [NCH-1:0]   sw_start_o,
  input  logic             dma_pend_i,
  output logic             dma_gnt_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i
);
  logic             rst_sync_n;
  logic             lim_arm, force_rel, active, work;
  logic [LIM_W-1:0] lim_val;

  dhl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dhl_regs #(.NCH(NCH), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_i), .addr(cfg_addr_t'(cfg_addr_i)),
    .wdata(cfg_wdata_i), .force_clr(force_rel), .ch_en(ch_en_o),
    .lim_arm(lim_arm), .lim_val(lim_val), .sw_start(sw_start_o)
  );

  always_comb begin
    active = lim_arm && (lim_val != '0);
    work   = dma_pend_i && (|ch_en_o);
  end

  dhl_occ_timer #(.LIM_W(LIM_W), .UNIT_LOG2(UNIT_LOG2), .BACKOFF(BACKOFF)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .work(work), .lim_val(lim_val),
    .bus_gnt(bus_gnt_i), .bus_req(bus_req_o), .dma_gnt(dma_gnt_o), .force_rel(force_rel)
  );

  assign lim_cfg_o = {lim_arm, lim_val};

  assert_gnt_gated_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_gnt_o |-> (bus_req_o && bus_gnt_i));

  assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dma_pend_i && |ch_en_o) |-> !bus_req_o);
endmodule

// File: tb/dma_hold_limiter_tb_top.sv
module dma_hold_limiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [5:0] ch_en, sw_start;
  logic [7:0] lim_cfg;
  logic       pend = 1'b0;
  logic       dma_gnt, bus_req;
  logic       bus_gnt;
  logic       arb_block = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  int exp_q[$];
  int run_len = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_hold_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .ch_en_o(ch_en), .lim_cfg_o(lim_cfg),
    .sw_start_o(sw_start), .dma_pend_i(pend), .dma_gnt_o(dma_gnt),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt)
  );

  // arbiter model: grant follows the request one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !arb_block;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures each grant run and compares with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (dma_gnt) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected grant run", run_len, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(run_len == e, "R4/R6/R8 grant run length", run_len, e);
        end
        run_len = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic expect_run(input int n);
    exp_q.push_back(n);
  endtask

  task automatic meas_gap(output int g);
    g = 0;
    @(negedge clk);
    while (bus_req) @(negedge clk);
    while (!bus_req) begin g++; @(negedge clk); end
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (bus_req) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step(1);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int gap;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk(ch_en == 6'd0, "R1 ch_en", ch_en, 0);
    chk(lim_cfg == 8'd0, "R1 limit word", lim_cfg, 0);
    chk(sw_start == 6'd0, "R1 sw_start", sw_start, 0);
    chk(bus_req == 1'b0, "R1 bus_req", bus_req, 0);

    // R9: pending work with no channel enabled makes no request
    pend = 1'b1; step(2);
    chk(bus_req == 1'b0, "R9 no request without channel", bus_req, 0);
    pend = 1'b0;

    // R3 limit write while unlocked: armed, 1 unit
    wr(2'd1, 8'h81);
    chk(lim_cfg == 8'h81, "R3 limit write", lim_cfg, 8'h81);
    // R2 channel enables
    wr(2'd0, 8'h05);
    chk(ch_en == 6'h05, "R2 channel enable", ch_en, 5);
    // R3 lock: write ignored while channels enabled
    wr(2'd1, 8'h82);
    chk(lim_cfg == 8'h81, "R3 limit locked", lim_cfg, 8'h81);
    // R7 software start load
    wr(2'd2, 8'h03);
    chk(sw_start == 6'h03, "R7 sw_start load", sw_start, 3);

    // R4/R5 forced release and back-off
    expect_run(256);
    pend = 1'b1;
    meas_gap(gap);
    chk(gap == 16, "R5 back-off gap", gap, 16);
    chk(sw_start == 6'h00, "R7 sw_start cleared on forced release", sw_start, 0);
    chk(bus_req == 1'b1, "R5 re-request after back-off", bus_req, 1);
    expect_run(256);
    step(1);
    wr(2'd2, 8'h20);
    wait_fall();
    chk(sw_start == 6'h00, "R7 sw_start cleared again", sw_start, 0);
    step(1);
    pend = 1'b0;
    step(20);
    drain();

    // R8 voluntary release, then a fresh full window
    expect_run(100);
    expect_run(256);
    pend = 1'b1;
    step(101);
    pend = 1'b0;
    step(5);
    pend = 1'b1;
    wait_fall();
    step(1);
    pend = 1'b0;
    step(20);
    drain();

    // R4 with two units
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h82);
    chk(lim_cfg == 8'h82, "R3 limit rewrite when unlocked", lim_cfg, 8'h82);
    wr(2'd0, 8'h3F);
    expect_run(512);
    pend = 1'b1;
    wait_fall();
    step(1);
    pend = 1'b0;
    step(20);
    drain();

    // R6 timer disarmed: no cap
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    expect_run(600);
    pend = 1'b1;
    step(601);
    pend = 1'b0;
    step(5);
    drain();

    // R6 armed with zero units: no cap
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h80);
    chk(lim_cfg == 8'h80, "R6 zero-unit limit stored", lim_cfg, 8'h80);
    wr(2'd0, 8'h02);
    expect_run(300);
    pend = 1'b1;
    step(301);
    pend = 1'b0;
    step(5);
    drain();

    // R9 grant gating while the arbiter withholds the bus
    arb_block = 1'b1;
    pend = 1'b1;
    step(4);
    chk(bus_req == 1'b1, "R9 request with work", bus_req, 1);
    chk(dma_gnt == 1'b0, "R9 no grant while withheld", dma_gnt, 0);
    pend = 1'b0;
    arb_block = 1'b0;
    step(5);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule